// File: doc/BRIEF.md
# Floating-point compare unit

This block compares two binary floating-point operands and returns a one-bit verdict. It also returns an invalid-operation flag. It is purely combinational. The verdict is widened with zeros to the width of an integer register so that it can be written straight back. A two-bit select picks one of three operations: less-or-equal, less-than or equal.

The comparison works on the raw bit patterns. Each operand is split into sign, exponent and mantissa and ordered by sign and magnitude, so no arithmetic subtraction is needed. NaN inputs are handled asymmetrically. The two ordered operations treat any NaN as an invalid operation. Equality complains only about signaling NaNs.

The exponent and mantissa widths are parameters. The defaults give single precision, and double precision is the same design with wider fields. A small control decoder turns the select into a set of strobes, and a datapath combines those strobes with the operand classification.

Top module: `fpcmp_unit`

## Requirements
- R1: With opSel = 0 (less-or-equal) and no NaN operand, bit 0 of cmpResult is 1 exactly when opA is less than or equal to opB.
- R2: With opSel = 1 (less-than) and no NaN operand, bit 0 of cmpResult is 1 exactly when opA is strictly less than opB.
- R3: With opSel = 2 (equal) and no NaN operand, bit 0 of cmpResult is 1 exactly when opA equals opB.
- R4: With opSel = 0 or 1, if either operand is a NaN (exponent all ones, mantissa nonzero), cmpResult is 0 and invalidFlag is 1.
- R5: With opSel = 2, a NaN operand makes cmpResult 0. invalidFlag is 1 only when an operand is a signaling NaN, meaning the mantissa's top bit is 0 and the mantissa is nonzero. A quiet NaN, whose mantissa top bit is 1, leaves invalidFlag at 0.
- R6: +0 (all bits zero) and -0 (only the sign bit set) compare equal, and neither is less than the other.
- R7: Two negative values order in reverse of their magnitudes, and any negative nonzero value is less than any positive value.
- R8: Infinities (exponent all ones, mantissa zero) order above or below every finite value according to their sign, and equal an infinity of the same sign.
- R9: Bits XLEN-1 down to 1 of cmpResult are always 0.
- R10: opSel = 3 is reserved. It yields cmpResult 0 and invalidFlag 0 for any operands, including NaNs.
- R11: When neither operand is a NaN, invalidFlag is 0 for every opSel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 1+EXP_W+MAN_W (32) | First operand, IEEE bit pattern |
| opB | input | 1+EXP_W+MAN_W (32) | Second operand, IEEE bit pattern |
| opSel | input | 2 | Operation: 0 less-or-equal, 1 less-than, 2 equal, 3 reserved |
| cmpResult | output | XLEN (32) | Verdict in bit 0, upper bits zero |
| invalidFlag | output | 1 | Invalid-operation exception |

## Verification
Two outputs can change on the same input change: the verdict is forced to zero, and the invalid flag is raised. This happens whenever a NaN meets an ordered operation, or a signaling NaN meets equality. The bench provokes it by pairing quiet and signaling NaNs with each select value, including a NaN paired with an ordinary number on either side. Both outputs are judged together at the same sampling point. The bench also pairs a quiet NaN with equality to show that the verdict drops without the flag.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [1:0] {
    OP_LE  = 2'd0,
    OP_LT  = 2'd1,
    OP_EQ  = 2'd2,
    OP_RSV = 2'd3
  } cmpOp_e;

  // Strobes sent from the decoder to the datapath
  typedef struct packed {
    logic useLess;   // verdict includes strict ordering
    logic useEqual;  // verdict includes equality
    logic nanTraps;  // any NaN raises invalid
    logic snanTraps; // only signaling NaN raises invalid
  } cmpStrobe_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int FLEN  = 1 + EXP_W + MAN_W,
  localparam int MAG_W = EXP_W + MAN_W
) (
  input  logic [FLEN-1:0]  opBits,
  output logic             signBit,
  output logic [MAG_W-1:0] magBits,
  output logic             isZero,
  output logic             isNan,
  output logic             isSnan
);

  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic             expAllOnes;
  logic             manNonZero;

  always_comb begin
    signBit    = opBits[FLEN-1];
    expField   = opBits[FLEN-2 -: EXP_W];
    manField   = opBits[MAN_W-1:0];
    magBits    = opBits[MAG_W-1:0];
    expAllOnes = &expField;
    manNonZero = |manField;
    isZero     = ~|magBits;
    isNan      = expAllOnes & manNonZero;
    isSnan     = isNan & ~manField[MAN_W-1];
  end

endmodule

// File: rtl/fpcmp_ctrl.sv
module fpcmp_ctrl
  import fpcmp_pkg::*;
(
  input  logic [1:0]  opSel,
  output cmpStrobe_t  strobes
);

  always_comb begin
    strobes = '0;
    case (cmpOp_e'(opSel))
      OP_LE: begin
        strobes.useLess  = 1'b1;
        strobes.useEqual = 1'b1;
        strobes.nanTraps = 1'b1;
      end
      OP_LT: begin
        strobes.useLess  = 1'b1;
        strobes.nanTraps = 1'b1;
      end
      OP_EQ: begin
        strobes.useEqual  = 1'b1;
        strobes.snanTraps = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

  always_comb begin
    AST_ONE_TRAP_POLICY: assert ($onehot0({strobes.nanTraps, strobes.snanTraps})) // R5
      else $error("both NaN trap policies active");
    AST_RSV_SILENT: assert (opSel != 2'd3 || strobes == '0) // R10
      else $error("reserved select produced strobes");
  end

endmodule

// File: rtl/fpcmp_datapath.sv
module fpcmp_datapath
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int FLEN  = 1 + EXP_W + MAN_W,
  localparam int MAG_W = EXP_W + MAN_W
) (
  input  logic [FLEN-1:0] opA,
  input  logic [FLEN-1:0] opB,
  input  cmpStrobe_t      strobes,
  output logic            verdict,
  output logic            invalid
);

  logic             signA, signB;
  logic [MAG_W-1:0] magA, magB;
  logic             zeroA, zeroB, nanA, nanB, snanA, snanB;
  logic             anyNan, anySnan, bothZero;
  logic             lessAB, equalAB;

  fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_clsA (
    .opBits(opA), .signBit(signA), .magBits(magA),
    .isZero(zeroA), .isNan(nanA), .isSnan(snanA)
  );

  fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_clsB (
    .opBits(opB), .signBit(signB), .magBits(magB),
    .isZero(zeroB), .isNan(nanB), .isSnan(snanB)
  );

  always_comb begin
    anyNan   = nanA | nanB;
    anySnan  = snanA | snanB;
    bothZero = zeroA & zeroB;

    // sign-magnitude ordering, zeros of either sign collapse
    if (anyNan || bothZero) begin
      lessAB = 1'b0;
    end else if (signA != signB) begin
      lessAB = signA;
    end else if (signA) begin
      lessAB = magA > magB;
    end else begin
      lessAB = magA < magB;
    end

    equalAB = ~anyNan & ((opA == opB) | bothZero);

    verdict = ~anyNan & ((strobes.useLess & lessAB) | (strobes.useEqual & equalAB));
    invalid = (strobes.nanTraps & anyNan) | (strobes.snanTraps & anySnan);
  end

  always_comb begin
    AST_ORDERED_NAN: assert (!(strobes.nanTraps && anyNan) || (!verdict && invalid)) // R4
      else $error("ordered compare with NaN misbehaved");
    AST_EQ_NAN_ZERO: assert (!(strobes.useEqual && !strobes.useLess && anyNan) || !verdict) // R5
      else $error("equality with NaN returned true");
    AST_ZERO_EQUAL: assert (!(bothZero && !anyNan) || (equalAB && !lessAB)) // R6
      else $error("signed zeros misordered");
    AST_LESS_EQ_EXCL: assert (!(lessAB && equalAB)) // R1
      else $error("less and equal both set");
    AST_NO_NAN_NO_FLAG: assert (anyNan || !invalid) // R11
      else $error("invalid raised without NaN");
  end

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int XLEN  = 32,
  localparam int FLEN = 1 + EXP_W + MAN_W
) (
  input  logic [FLEN-1:0] opA,
  input  logic [FLEN-1:0] opB,
  input  logic [1:0]      opSel,
  output logic [XLEN-1:0] cmpResult,
  output logic            invalidFlag
);

  cmpStrobe_t strobes;
  logic       verdict;

  fpcmp_ctrl u_ctrl (
    .opSel  (opSel),
    .strobes(strobes)
  );

  fpcmp_datapath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dp (
    .opA    (opA),
    .opB    (opB),
    .strobes(strobes),
    .verdict(verdict),
    .invalid(invalidFlag)
  );

  assign cmpResult = {{(XLEN-1){1'b0}}, verdict};

  always_comb begin
    AST_RSV_QUIET: assert (opSel != 2'd3 || (cmpResult == '0 && !invalidFlag)) // R10
      else $error("reserved select not quiet");
  end

endmodule

// File: tb/tb_fpcmp_unit.sv
module tb_fpcmp_unit;

  localparam int XLEN = 32;

  localparam logic [31:0] P_ZERO = 32'h0000_0000;
  localparam logic [31:0] N_ZERO = 32'h8000_0000;
  localparam logic [31:0] P_ONE  = 32'h3F80_0000;
  localparam logic [31:0] N_ONE  = 32'hBF80_0000;
  localparam logic [31:0] P_TWO  = 32'h4000_0000;
  localparam logic [31:0] N_TWO  = 32'hC000_0000;
  localparam logic [31:0] P_INF  = 32'h7F80_0000;
  localparam logic [31:0] N_INF  = 32'hFF80_0000;
  localparam logic [31:0] P_MAX  = 32'h7F7F_FFFF;
  localparam logic [31:0] P_TINY = 32'h0000_0001;
  localparam logic [31:0] Q_NAN  = 32'h7FC0_0000;
  localparam logic [31:0] S_NAN  = 32'h7F80_0001;
  localparam logic [31:0] S_NANN = 32'hFFA0_0000;

  logic            clk = 1'b0;
  logic [31:0]     opA = '0;
  logic [31:0]     opB = '0;
  logic [1:0]      opSel = 2'd0;
  logic [XLEN-1:0] cmpResult;
  logic            invalidFlag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fpcmp_unit dut (
    .opA(opA), .opB(opB), .opSel(opSel),
    .cmpResult(cmpResult), .invalidFlag(invalidFlag)
  );

  task automatic apply_check(input string req, input logic [31:0] a,
                             input logic [31:0] b, input logic [1:0] sel,
                             input logic expRes, input logic expInv);
    @(posedge clk);
    opA = a; opB = b; opSel = sel;
    @(negedge clk);
    checks++;
    if (cmpResult !== {{(XLEN-1){1'b0}}, expRes} || invalidFlag !== expInv) begin
      errors++;
      $display("FAIL %s: a=%h b=%h sel=%0d got res=%h inv=%b exp res=%0b inv=%b",
               req, a, b, sel, cmpResult, invalidFlag, expRes, expInv);
    end
  endtask

  task automatic t_idle_state;   // R9 with default inputs (+0 <= +0)
    apply_check("R9", P_ZERO, P_ZERO, 2'd0, 1'b1, 1'b0);
  endtask

  task automatic t_less_equal;   // R1
    apply_check("R1", P_ONE, P_TWO, 2'd0, 1'b1, 1'b0);
    apply_check("R1", P_TWO, P_ONE, 2'd0, 1'b0, 1'b0);
    apply_check("R1", P_TWO, P_TWO, 2'd0, 1'b1, 1'b0);
    apply_check("R1", P_TINY, P_ZERO, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_less_than;    // R2
    apply_check("R2", P_ONE, P_TWO, 2'd1, 1'b1, 1'b0);
    apply_check("R2", P_TWO, P_TWO, 2'd1, 1'b0, 1'b0);
    apply_check("R2", P_ZERO, P_TINY, 2'd1, 1'b1, 1'b0);
  endtask

  task automatic t_equal;        // R3
    apply_check("R3", P_TWO, P_TWO, 2'd2, 1'b1, 1'b0);
    apply_check("R3", P_ONE, P_TWO, 2'd2, 1'b0, 1'b0);
    apply_check("R3", P_ONE, N_ONE, 2'd2, 1'b0, 1'b0);
  endtask

  task automatic t_ordered_nan;  // R4
    apply_check("R4", Q_NAN, P_ONE, 2'd0, 1'b0, 1'b1);
    apply_check("R4", P_ONE, Q_NAN, 2'd1, 1'b0, 1'b1);
    apply_check("R4", S_NAN, S_NAN, 2'd0, 1'b0, 1'b1);
    apply_check("R4", N_INF, S_NANN, 2'd1, 1'b0, 1'b1);
  endtask

  task automatic t_equal_nan;    // R5
    apply_check("R5", Q_NAN, Q_NAN, 2'd2, 1'b0, 1'b0);
    apply_check("R5", P_ONE, Q_NAN, 2'd2, 1'b0, 1'b0);
    apply_check("R5", S_NAN, P_ONE, 2'd2, 1'b0, 1'b1);
    apply_check("R5", Q_NAN, S_NANN, 2'd2, 1'b0, 1'b1);
  endtask

  task automatic t_signed_zero;  // R6
    apply_check("R6", P_ZERO, N_ZERO, 2'd2, 1'b1, 1'b0);
    apply_check("R6", N_ZERO, P_ZERO, 2'd1, 1'b0, 1'b0);
    apply_check("R6", P_ZERO, N_ZERO, 2'd1, 1'b0, 1'b0);
    apply_check("R6", P_ZERO, N_ZERO, 2'd0, 1'b1, 1'b0);
  endtask

  task automatic t_negatives;    // R7
    apply_check("R7", N_TWO, N_ONE, 2'd1, 1'b1, 1'b0);
    apply_check("R7", N_ONE, N_TWO, 2'd1, 1'b0, 1'b0);
    apply_check("R7", N_ONE, N_TWO, 2'd0, 1'b0, 1'b0);
    apply_check("R7", N_ONE, P_TINY, 2'd1, 1'b1, 1'b0);
    apply_check("R7", P_TINY, N_ONE, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_infinities;   // R8
    apply_check("R8", P_MAX, P_INF, 2'd1, 1'b1, 1'b0);
    apply_check("R8", P_INF, P_MAX, 2'd0, 1'b0, 1'b0);
    apply_check("R8", N_INF, N_TWO, 2'd1, 1'b1, 1'b0);
    apply_check("R8", P_INF, P_INF, 2'd2, 1'b1, 1'b0);
    apply_check("R8", P_INF, N_INF, 2'd2, 1'b0, 1'b0);
    apply_check("R8", N_INF, N_INF, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic t_reserved;     // R10
    apply_check("R10", P_ONE, P_TWO, 2'd3, 1'b0, 1'b0);
    apply_check("R10", P_TWO, P_TWO, 2'd3, 1'b0, 1'b0);
    apply_check("R10", S_NAN, Q_NAN, 2'd3, 1'b0, 1'b0);
  endtask

  task automatic t_no_spurious;  // R11
    for (int s = 0; s < 4; s++) begin
      apply_check("R11", N_INF, P_INF, 2'(s), (s == 0 || s == 1), 1'b0);
    end
  endtask

  initial begin
    fork
      begin
        t_idle_state();
        t_less_equal();
        t_less_than();
        t_equal();
        t_ordered_nan();
        t_equal_nan();
        t_signed_zero();
        t_negatives();
        t_infinities();
        t_reserved();
        t_no_spurious();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule